// File: doc/BRIEF.md
# UART Transmit Bypass and Driver Control

This block sits between the host's byte writes, a transmit FIFO and the transmit shift register of a UART. Normally, with the FIFO enabled, each accepted host byte is pushed into the FIFO. The FIFO head is moved into the shift register whenever the shifter is free. Software can arm a one-shot send-now flag. When the flag is armed, the next byte the host writes is captured into a hold register and is not queued. It goes to the shift register as soon as the current character ends, ahead of anything already waiting in the FIFO. The flag clears by itself once that byte has been fully shifted out, so every further bypassed byte needs a new arm pulse. When the FIFO is disabled, host bytes go straight to the shift register and the flag changes nothing.

The block also produces the pin-level values and output enables for the serial data, RTS# and DTR# lines. In RS485 mode, RTS# takes a selectable level while a character is in flight and the opposite level otherwise. A high-impedance control drops all three output enables together.

Three interfaces carry bytes, and each uses valid/ready. On the host write channel a byte transfers on a cycle with both `wr_valid` and `wr_ready` high, and the host must hold its byte while it is stalled. `wr_ready` never depends on `wr_valid`. The push channel passes back-pressure from the FIFO straight to the host, except while an armed capture is pending. On the FIFO head channel, `fd_ready` is the pop and is raised only in the cycle the head byte is loaded.

Top module: `uart_txbyp_ctrl`

## Requirements
- R1: After reset the send-now flag is 0, and `sh_load`, `fq_valid` and `fd_ready` are 0 while no FIFO data is waiting.
- R2: With the flag at 0 and `fifo_en` at 1, `fq_valid` equals `wr_valid`, `fq_data` equals `wr_data`, and `wr_ready` equals `fq_ready`.
- R3: With the flag armed and `fifo_en` at 1, `wr_ready` is 1 and `fq_valid` is 0. The byte written in that state is captured and is loaded into the shifter at the first free cycle, before any queued FIFO byte.
- R4: Only the first byte written after arming is bypassed; later writes go to the push channel even while the captured byte waits or is being sent.
- R5: The flag reads 0 in the cycle after `sh_done` pulses for the bypassed byte. An arm pulse while the flag is already 1 has no effect.
- R6: With `fifo_en` at 0, `wr_ready` is high exactly when the shifter is free and no captured byte waits. An accepted write is loaded in the same cycle, and the flag is left unchanged by such writes.
- R7: With `fifo_en` at 1, when the shifter is free, no captured byte waits and `fd_valid` is 1, `fd_ready` and `sh_load` are 1 with `sh_data` equal to `fd_data`.
- R8: The shifter is free when `sh_busy` is 0 and `sh_load` was 0 in the previous cycle. A load never happens while it is not free.
- R9: With `rs485_en` at 1, `rts_n_o` equals `rts_inv` while a character is active (`sh_busy` high, or a load in the previous cycle), and its complement otherwise. With `rs485_en` at 0, it follows `rts_n_base`.
- R10: With `drv_hiz` at 1, `tx_oe`, `rts_oe` and `dtr_oe` are 0, and they are 1 otherwise. `tx_o` follows `tx_ser` and `dtr_n_o` follows `dtr_n_base` in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | Transmit FIFO enabled |
| sendnow_set | input | 1 | One-cycle pulse that arms the send-now flag |
| rs485_en | input | 1 | RS485 direction control on RTS# |
| rts_inv | input | 1 | RTS# level while transmitting in RS485 mode |
| drv_hiz | input | 1 | Release serial and modem outputs |
| wr_valid | input | 1 | Host byte valid |
| wr_ready | output | 1 | Host byte accepted |
| wr_data | input | DATA_W | Host byte |
| fq_valid | output | 1 | Push to FIFO valid |
| fq_ready | input | 1 | FIFO has room |
| fq_data | output | DATA_W | Byte pushed to FIFO |
| fd_valid | input | 1 | FIFO head valid |
| fd_ready | output | 1 | Pop FIFO head |
| fd_data | input | DATA_W | FIFO head byte |
| sh_load | output | 1 | Load shift register |
| sh_data | output | DATA_W | Byte loaded into shift register |
| sh_busy | input | 1 | Shift register sending |
| sh_done | input | 1 | Last stop bit leaves this cycle |
| sendnow_flag | output | 1 | Current state of the send-now flag |
| tx_ser | input | 1 | Serial bit from the shift register |
| rts_n_base | input | 1 | RTS# value from modem control |
| dtr_n_base | input | 1 | DTR# value from modem control |
| tx_o | output | 1 | Serial output value |
| tx_oe | output | 1 | Serial output enable |
| rts_n_o | output | 1 | RTS# output value |
| rts_oe | output | 1 | RTS# output enable |
| dtr_n_o | output | 1 | DTR# output value |
| dtr_oe | output | 1 | DTR# output enable |

## Verification
The first pattern is a burst of host bytes with the FIFO enabled and long characters on the shifter. The FIFO fills, so pass-through back-pressure and in-order draining can be told apart from accidental bypassing. The second pattern arms the flag while the shifter is busy and the FIFO holds data, then writes more bytes. This separates a correct ahead-of-queue load of exactly one byte from a bypass that stays open or is served late, and it shows the self-clear at the end of that character. With the FIFO disabled and the flag armed, direct writes show that the flag neither reroutes bytes nor gets used up. Toggling RTS polarity, RS485 mode and high impedance during traffic separates the active-character window from the idle level.

// File: rtl/uart_txbyp_pkg.sv
package uart_txbyp_pkg;
  typedef enum logic [1:0] {
    BP_IDLE  = 2'd0,
    BP_ARMED = 2'd1,
    BP_HELD  = 2'd2,
    BP_SEND  = 2'd3
  } bp_state_e;
endpackage

// File: rtl/uart_txbyp_fsm.sv
module uart_txbyp_fsm
  import uart_txbyp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              fifo_en_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  input  logic              done_i,
  output bp_state_e         state_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              capture_o
);
  bp_state_e         state_q, state_d;
  logic [DATA_W-1:0] hold_q;

  // an armed flag takes the next write only when the FIFO path is active
  assign capture_o = (state_q == BP_ARMED) && fifo_en_i && wr_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BP_IDLE:  if (set_i)     state_d = BP_ARMED;
      BP_ARMED: if (capture_o) state_d = BP_HELD;
      BP_HELD:  if (take_i)    state_d = BP_SEND;
      BP_SEND:  if (done_i)    state_d = BP_IDLE;
      default:                 state_d = BP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BP_IDLE;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (capture_o) hold_q <= wr_data_i;
    end
  end

  assign state_o = state_q;
  assign hold_o  = hold_q;
endmodule

// File: rtl/uart_txbyp_arb.sv
module uart_txbyp_arb
  import uart_txbyp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bp_state_e         state_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic              fifo_en_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  output logic              fq_valid_o,
  output logic [DATA_W-1:0] fq_data_o,
  input  logic              fq_ready_i,
  input  logic              fd_valid_i,
  input  logic [DATA_W-1:0] fd_data_i,
  output logic              fd_ready_o,
  input  logic              sh_busy_i,
  output logic              take_o,
  output logic              sh_load_o,
  output logic [DATA_W-1:0] sh_data_o,
  output logic              active_o
);
  logic load_q;
  logic free;
  logic held;
  logic armed_cap;
  logic direct;

  // busy from the shifter arrives one cycle after a load
  assign free      = !sh_busy_i && !load_q;
  assign held      = (state_i == BP_HELD);
  assign armed_cap = (state_i == BP_ARMED) && fifo_en_i;

  always_comb begin
    if (armed_cap)      wr_ready_o = 1'b1;
    else if (fifo_en_i) wr_ready_o = fq_ready_i;
    else                wr_ready_o = free && !held;
  end

  assign fq_valid_o = wr_valid_i && fifo_en_i && !armed_cap;
  assign fq_data_o  = wr_data_i;

  assign take_o     = free && held;
  assign fd_ready_o = free && !held && fifo_en_i && fd_valid_i;
  assign direct     = free && !held && !fifo_en_i && wr_valid_i;
  assign sh_load_o  = take_o || fd_ready_o || direct;

  always_comb begin
    if (take_o)          sh_data_o = hold_i;
    else if (fd_ready_o) sh_data_o = fd_data_i;
    else                 sh_data_o = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= 1'b0;
    else        load_q <= sh_load_o;
  end

  assign active_o = sh_busy_i || load_q;
endmodule

// File: rtl/uart_txbyp_pins.sv
module uart_txbyp_pins (
  input  logic rs485_en_i,
  input  logic rts_inv_i,
  input  logic drv_hiz_i,
  input  logic active_i,
  input  logic tx_ser_i,
  input  logic rts_n_base_i,
  input  logic dtr_n_base_i,
  output logic tx_o,
  output logic tx_oe,
  output logic rts_n_o,
  output logic rts_oe,
  output logic dtr_n_o,
  output logic dtr_oe
);
  logic dir_level;

  // direction level: selected polarity while a character is in flight
  assign dir_level = active_i ? rts_inv_i : !rts_inv_i;

  assign tx_o    = tx_ser_i;
  assign rts_n_o = rs485_en_i ? dir_level : rts_n_base_i;
  assign dtr_n_o = dtr_n_base_i;

  assign tx_oe  = !drv_hiz_i;
  assign rts_oe = !drv_hiz_i;
  assign dtr_oe = !drv_hiz_i;
endmodule

// File: rtl/uart_txbyp_ctrl.sv
module uart_txbyp_ctrl
  import uart_txbyp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              sendnow_set,
  input  logic              rs485_en,
  input  logic              rts_inv,
  input  logic              drv_hiz,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fq_valid,
  input  logic              fq_ready,
  output logic [DATA_W-1:0] fq_data,
  input  logic              fd_valid,
  output logic              fd_ready,
  input  logic [DATA_W-1:0] fd_data,
  output logic              sh_load,
  output logic [DATA_W-1:0] sh_data,
  input  logic              sh_busy,
  input  logic              sh_done,
  output logic              sendnow_flag,
  input  logic              tx_ser,
  input  logic              rts_n_base,
  input  logic              dtr_n_base,
  output logic              tx_o,
  output logic              tx_oe,
  output logic              rts_n_o,
  output logic              rts_oe,
  output logic              dtr_n_o,
  output logic              dtr_oe
);
  bp_state_e         bp_state;
  logic [DATA_W-1:0] hold_byte;
  logic              capture;
  logic              take;
  logic              active;

  uart_txbyp_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (sendnow_set),
    .fifo_en_i  (fifo_en),
    .wr_valid_i (wr_valid),
    .wr_data_i  (wr_data),
    .take_i     (take),
    .done_i     (sh_done),
    .state_o    (bp_state),
    .hold_o     (hold_byte),
    .capture_o  (capture)
  );

  uart_txbyp_arb #(.DATA_W(DATA_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_i    (bp_state),
    .hold_i     (hold_byte),
    .fifo_en_i  (fifo_en),
    .wr_valid_i (wr_valid),
    .wr_data_i  (wr_data),
    .wr_ready_o (wr_ready),
    .fq_valid_o (fq_valid),
    .fq_data_o  (fq_data),
    .fq_ready_i (fq_ready),
    .fd_valid_i (fd_valid),
    .fd_data_i  (fd_data),
    .fd_ready_o (fd_ready),
    .sh_busy_i  (sh_busy),
    .take_o     (take),
    .sh_load_o  (sh_load),
    .sh_data_o  (sh_data),
    .active_o   (active)
  );

  uart_txbyp_pins u_pins (
    .rs485_en_i   (rs485_en),
    .rts_inv_i    (rts_inv),
    .drv_hiz_i    (drv_hiz),
    .active_i     (active),
    .tx_ser_i     (tx_ser),
    .rts_n_base_i (rts_n_base),
    .dtr_n_base_i (dtr_n_base),
    .tx_o         (tx_o),
    .tx_oe        (tx_oe),
    .rts_n_o      (rts_n_o),
    .rts_oe       (rts_oe),
    .dtr_n_o      (dtr_n_o),
    .dtr_oe       (dtr_oe)
  );

  assign sendnow_flag = (bp_state != BP_IDLE);

  logic unused_capture;
  assign unused_capture = capture;
endmodule

// File: rtl/uart_txbyp_chk.sv
module uart_txbyp_chk
  import uart_txbyp_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input bp_state_e state,
  input logic      fifo_en,
  input logic      wr_valid,
  input logic      wr_ready,
  input logic      fq_valid,
  input logic      fd_valid,
  input logic      fd_ready,
  input logic      sh_load,
  input logic      sh_busy,
  input logic      sh_done,
  input logic      sendnow_flag
);
  a_r8_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |=> !sh_load);

  a_r8_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |-> !sh_busy);

  a_r7_pop_loads: assert property (@(posedge clk) disable iff (!rst_n)
    fd_ready |-> (fd_valid && sh_load));

  a_r2_push_from_host: assert property (@(posedge clk) disable iff (!rst_n)
    fq_valid |-> (wr_valid && fifo_en));

  a_r3_capture_not_pushed: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BP_ARMED && fifo_en) |-> (!fq_valid && wr_ready));

  a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BP_SEND && sh_done) |=> !sendnow_flag);

  a_r6_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && wr_valid && wr_ready) |-> sh_load);
endmodule

bind uart_txbyp_ctrl uart_txbyp_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .state        (bp_state),
  .fifo_en      (fifo_en),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .fq_valid     (fq_valid),
  .fd_valid     (fd_valid),
  .fd_ready     (fd_ready),
  .sh_load      (sh_load),
  .sh_busy      (sh_busy),
  .sh_done      (sh_done),
  .sendnow_flag (sendnow_flag)
);

// File: tb/uart_txbyp_ctrl_bench.sv
module uart_txbyp_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int CHAR_CYC   = 6;
  localparam int FIFO_CAP   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0, sendnow_set = 1'b0, rs485_en = 1'b0, rts_inv = 1'b0, drv_hiz = 1'b0;
  logic wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic fq_ready = 1'b0, fd_valid = 1'b0, sh_busy = 1'b0, sh_done = 1'b0;
  logic [DW-1:0] fd_data = '0;
  logic tx_ser = 1'b1, rts_n_base = 1'b1, dtr_n_base = 1'b1;
  logic wr_ready, fq_valid, fd_ready, sh_load, sendnow_flag;
  logic [DW-1:0] fq_data, sh_data;
  logic tx_o, tx_oe, rts_n_o, rts_oe, dtr_n_o, dtr_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_txbyp_ctrl #(.DATA_W(DW)) u_uart_txbyp_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .sendnow_set(sendnow_set),
    .rs485_en(rs485_en), .rts_inv(rts_inv), .drv_hiz(drv_hiz),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_data(fq_data),
    .fd_valid(fd_valid), .fd_ready(fd_ready), .fd_data(fd_data),
    .sh_load(sh_load), .sh_data(sh_data), .sh_busy(sh_busy), .sh_done(sh_done),
    .sendnow_flag(sendnow_flag), .tx_ser(tx_ser), .rts_n_base(rts_n_base),
    .dtr_n_base(dtr_n_base), .tx_o(tx_o), .tx_oe(tx_oe), .rts_n_o(rts_n_o),
    .rts_oe(rts_oe), .dtr_n_o(dtr_n_o), .dtr_oe(dtr_oe)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit acc;

  // reference state: 0 idle, 1 armed, 2 held, 3 sending
  int            m_st = 0;
  logic [DW-1:0] m_hold = '0;
  bit            m_loadr = 0;
  logic [DW-1:0] fifo_q[$];
  int            busy_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic drive_env();
    fq_ready = (fifo_q.size() < FIFO_CAP);
    fd_valid = (fifo_q.size() > 0);
    fd_data  = (fifo_q.size() > 0) ? fifo_q[0] : '0;
    sh_busy  = (busy_cnt > 0);
    sh_done  = (busy_cnt == 1);
    tx_ser   = (busy_cnt % 2 == 1);
  endtask

  task automatic step();
    bit free, cap, e_rdy, e_fqv, take, e_pop, direct, e_load, active, e_rts, pushed;
    logic [DW-1:0] e_dat;
    drive_env();
    @(negedge clk);
    free   = !sh_busy && !m_loadr;
    cap    = (m_st == 1) && fifo_en && wr_valid;
    if (m_st == 1 && fifo_en) e_rdy = 1;
    else if (fifo_en)         e_rdy = fq_ready;
    else                      e_rdy = free && (m_st != 2);
    e_fqv  = wr_valid && fifo_en && !(m_st == 1);
    take   = free && (m_st == 2);
    e_pop  = free && (m_st != 2) && fifo_en && fd_valid;
    direct = free && (m_st != 2) && !fifo_en && wr_valid;
    e_load = take || e_pop || direct;
    e_dat  = take ? m_hold : (e_pop ? fd_data : wr_data);
    active = sh_busy || m_loadr;
    e_rts  = rs485_en ? (active ? rts_inv : !rts_inv) : rts_n_base;
    acc    = wr_valid && wr_ready;
    pushed = fq_valid && fq_ready;
    if (rst_n) begin
      chk(wr_ready == e_rdy, "R3 wr_ready", wr_ready, e_rdy);
      chk(fq_valid == e_fqv, "R2 fq_valid", fq_valid, e_fqv);
      if (e_fqv) chk(fq_data == wr_data, "R2 fq_data", fq_data, wr_data);
      chk(fd_ready == e_pop, "R7 fd_ready", fd_ready, e_pop);
      chk(sh_load == e_load, "R8 sh_load", sh_load, e_load);
      if (e_load) chk(sh_data == e_dat, "R3 sh_data order", sh_data, e_dat);
      chk(sendnow_flag == (m_st != 0), "R5 flag", sendnow_flag, m_st != 0);
      chk(rts_n_o == e_rts, "R9 rts_n_o", rts_n_o, e_rts);
      chk({tx_oe, rts_oe, dtr_oe} == {3{!drv_hiz}}, "R10 enables",
          {tx_oe, rts_oe, dtr_oe}, {3{!drv_hiz}});
      chk(tx_o == tx_ser && dtr_n_o == dtr_n_base, "R10 values",
          {tx_o, dtr_n_o}, {tx_ser, dtr_n_base});
    end
    @(posedge clk);
    #1;
    if (!rst_n) begin
      m_st = 0; m_loadr = 0; busy_cnt = 0; fifo_q.delete();
    end else begin
      case (m_st)
        0: if (sendnow_set) m_st = 1;
        1: if (cap) begin m_st = 2; m_hold = wr_data; end
        2: if (take) m_st = 3;
        default: if (sh_done) m_st = 0;
      endcase
      m_loadr = e_load;
      if (e_pop) void'(fifo_q.pop_front());
      if (pushed) fifo_q.push_back(fq_data);
      if (e_load) busy_cnt = CHAR_CYC;
      else if (busy_cnt > 0) busy_cnt--;
    end
    drive_env();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    do step(); while (!acc);
    wr_valid = 1'b0;
  endtask

  task automatic arm();
    sendnow_set = 1'b1;
    step();
    sendnow_set = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(sendnow_flag == 1'b0 && sh_load == 1'b0 && fq_valid == 1'b0 && fd_ready == 1'b0,
        "R1 reset", {sendnow_flag, sh_load, fq_valid, fd_ready}, 0);
    idle(2);

    // R2 R7 queued burst with back-pressure
    fifo_en = 1'b1; rs485_en = 1'b1;
    for (int i = 1; i <= 6; i++) wr(DW'(8'h10 * i + i));

    // R3 R4 bypass while busy with data queued
    arm();
    wr(8'hA5);
    chk(sendnow_flag == 1'b1, "R3 flag after capture", sendnow_flag, 1);
    arm();   // R5 pulse while set is ignored
    wr(8'h77);
    wr(8'h88);
    chk(fifo_q.size() > 0 && fifo_q[$] == 8'h88, "R4 later write queued",
        fifo_q.size() > 0 ? fifo_q[$] : 0, 8'h88);
    idle(80);
    chk(sendnow_flag == 1'b0, "R5 flag cleared", sendnow_flag, 0);

    // R9 R10 pin control during traffic
    rts_inv = 1'b1;
    wr(8'h99);
    idle(3);
    drv_hiz = 1'b1; dtr_n_base = 1'b0;
    idle(6);
    drv_hiz = 1'b0;
    idle(10);

    // R6 FIFO disabled, armed flag untouched
    fifo_en = 1'b0;
    arm();
    wr(8'hC3);
    wr(8'h3D);
    idle(8);
    chk(sendnow_flag == 1'b1, "R6 flag kept", sendnow_flag, 1);

    // R3 armed flag applies once FIFO is enabled
    fifo_en = 1'b1;
    wr(8'h3C);
    idle(20);
    chk(sendnow_flag == 1'b0, "R5 flag cleared again", sendnow_flag, 0);

    // R9 non-485 mode follows base
    rs485_en = 1'b0; rts_n_base = 1'b0;
    wr(8'h5A);
    rts_n_base = 1'b1;
    idle(12);
    finish_run();
  end
endmodule